// File: doc/BRIEF.md
# Rotating Bus Arbitration ID Tracker

This block holds the 4-bit arbitration priority of one agent that shares a serial interrupt message bus with other agents. After every arbitration round the whole bus learns the winner's ID, and each agent applies the same rotating rule to its own value. The winner falls to the bottom (zero). The others move up by one. An agent already at the top (15) cannot move up, so it takes the winner's old slot plus one. Because every agent applies the rule in step, the IDs stay distinct and every agent eventually reaches the top.

A round updates the priority only when its message got through. A message gets through when neither a checksum error nor an acceptance error was reported. Lowest-priority messages are the exception: they rotate the priorities even when they fail. Two events reload the priority from the agent's own ID: a write to the ID register, and a level-triggered INIT deassert message.

The block also runs the contest itself on a single open-collector line, where low is dominant. Starting with the most significant bit, the agent pulls the line low for each 1 bit of its priority. As long as it is still in the race, the value it drives is the inverse of its ID bit. An agent drops out when it releases the line but reads it back low. The highest priority therefore wins. The result is reported to the message sender as a one-cycle pulse.

Top module: `arb_id_tracker`

## Requirements
- R1: During and right after synchronous reset `rst`, `arb_id` is 0, `arb_line_out` is 1 (released), and `arb_busy`, `arb_won` and `arb_lost` are 0.
- R2: When `id_wr` is high at a clock edge, `arb_id` equals `agent_id` from the next cycle.
- R3: When `init_deassert` is high at a clock edge, `arb_id` equals `agent_id` from the next cycle.
- R4: On `round_done` with the update enabled, where the update is enabled when `tx_ok` or `lowpri` is 1, an agent whose `arb_id` equals `winner_id` becomes 0 in the next cycle.
- R5: On an enabled `round_done` where `arb_id` is 15 and differs from `winner_id`, `arb_id` becomes (`winner_id` + 1) mod 16.
- R6: On an enabled `round_done` in every other case, `arb_id` becomes `arb_id` + 1.
- R7: When `round_done` arrives with `tx_ok`=0 and `lowpri`=0, `arb_id` is unchanged.
- R8: When `lowpri`=1, `round_done` applies R4 to R6 even with `tx_ok`=0.
- R9: A reload (`id_wr` or `init_deassert`) in the same cycle as `round_done` takes precedence, and `arb_id` becomes `agent_id`.
- R10: A race started by `arb_start` while idle lasts 4 cycles and sends the ID captured at the start, MSB first. In race cycle k, while still in contention, `arb_line_out` is the inverse of bit 3-k. `arb_line_out` is 1 when idle or after dropping out.
- R11: If the agent releases the line (`arb_line_out`=1) during a race but reads `arb_line_in`=0 at the edge, it drops out and releases the line for the rest of the race.
- R12: In the cycle after the fourth bit, exactly one of `arb_won` and `arb_lost` pulses high for one cycle. `arb_won` pulses when the agent never dropped out, which for distinct IDs means its ID is larger than every rival's.
- R13: `arb_start` is ignored while a race is running: the race ends on its original schedule and no second race follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_wr | input | 1 | ID register write: reload priority from `agent_id` |
| init_deassert | input | 1 | Level INIT deassert message seen: reload priority |
| agent_id | input | 4 | The agent's own ID |
| round_done | input | 1 | Arbitration round finished: apply the rotation rule |
| winner_id | input | 4 | Priority the round's winner held before the round |
| tx_ok | input | 1 | Message completed without checksum or acceptance error |
| lowpri | input | 1 | The message was a lowest-priority message |
| arb_start | input | 1 | Begin a bit-serial race with the current priority |
| arb_line_in | input | 1 | Value read back from the wired-AND line |
| arb_line_out | output | 1 | Value driven to the wired-AND line (0 dominant) |
| arb_busy | output | 1 | Race in progress |
| arb_won | output | 1 | One-cycle pulse: race won |
| arb_lost | output | 1 | One-cycle pulse: race lost |
| arb_id | output | 4 | Current arbitration priority |

## Verification
The checker watches the following on every cycle: the reset value, the reload paths, the self-win drop to zero, and holding on failed non-lowest-priority rounds. It also checks that a dropped-out agent keeps the line released, that the line is released while idle, and that the win and lose pulses never overlap and never last two cycles. Other behaviours show up only in the bench's sweeps, which compare against arithmetic expectations. These sweeps cover the rotation outcome for every pair of current and winner priority under every flag combination, and the race result and per-bit line value for every ordered pair of distinct IDs. They also cover the precedence of reloads and the ignoring of a start request during a race.

// File: rtl/arb_id_pkg.sv
package arb_id_pkg;

    localparam int ARB_ID_W = 4;

    typedef logic [ARB_ID_W-1:0] arb_id_t;

    // one arbitration round outcome as seen by this agent
    typedef struct packed {
        logic    valid;
        arb_id_t winner;
        logic    ok;
        logic    lowpri;
    } round_evt_t;

    typedef enum logic {
        RACE_IDLE = 1'b0,
        RACE_RUN  = 1'b1
    } race_state_t;

    // rotating-priority rule applied by every agent after a round
    function automatic arb_id_t rotate_id(input arb_id_t cur, input arb_id_t win);
        arb_id_t top;
        top = '1;
        if (cur == win)      return '0;
        else if (cur == top) return arb_id_t'(win + 1'b1);
        else                 return arb_id_t'(cur + 1'b1);
    endfunction

    function automatic logic round_counts(input round_evt_t ev);
        return ev.valid && (ev.ok || ev.lowpri);
    endfunction

endpackage

// File: rtl/arb_id_next.sv
module arb_id_next
    import arb_id_pkg::*;
(
    input  arb_id_t    cur_id,
    input  logic       reload,
    input  arb_id_t    reload_val,
    input  round_evt_t round_ev,
    output arb_id_t    next_id
);
    always_comb begin
        if (reload)
            next_id = reload_val;
        else if (round_counts(round_ev))
            next_id = rotate_id(cur_id, round_ev.winner);
        else
            next_id = cur_id;
    end
endmodule

// File: rtl/arb_race.sv
module arb_race
    import arb_id_pkg::*;
#(
    parameter int W = ARB_ID_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] id_in,
    input  logic         line_in,
    output logic         line_out,
    output logic         busy,
    output logic         won,
    output logic         lost
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(W - 1);

    race_state_t  state_q;
    logic [IW-1:0] idx_q;
    logic          in_q;
    logic [W-1:0]  shot_q;
    logic          won_q;
    logic          lost_q;
    logic          knocked;
    logic          still_in;

    // dominant 0 for a 1 bit: the larger ID pulls the line low first
    assign line_out = (state_q == RACE_RUN && in_q) ? ~shot_q[idx_q] : 1'b1;
    assign knocked  = line_out && !line_in;
    assign still_in = in_q && !knocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RACE_IDLE;
            idx_q   <= '0;
            in_q    <= 1'b0;
            shot_q  <= '0;
            won_q   <= 1'b0;
            lost_q  <= 1'b0;
        end else begin
            won_q  <= 1'b0;
            lost_q <= 1'b0;
            case (state_q)
                RACE_IDLE: begin
                    if (start) begin
                        state_q <= RACE_RUN;
                        idx_q   <= LAST_BIT;
                        in_q    <= 1'b1;
                        shot_q  <= id_in;
                    end
                end
                RACE_RUN: begin
                    in_q <= still_in;
                    if (idx_q == '0) begin
                        state_q <= RACE_IDLE;
                        won_q   <= still_in;
                        lost_q  <= !still_in;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                default: state_q <= RACE_IDLE;
            endcase
        end
    end

    assign busy = (state_q == RACE_RUN);
    assign won  = won_q;
    assign lost = lost_q;
endmodule

// File: rtl/arb_id_tracker.sv
module arb_id_tracker
    import arb_id_pkg::*;
#(
    parameter int W = ARB_ID_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         id_wr,
    input  logic         init_deassert,
    input  logic [W-1:0] agent_id,
    input  logic         round_done,
    input  logic [W-1:0] winner_id,
    input  logic         tx_ok,
    input  logic         lowpri,
    input  logic         arb_start,
    input  logic         arb_line_in,
    output logic         arb_line_out,
    output logic         arb_busy,
    output logic         arb_won,
    output logic         arb_lost,
    output logic [W-1:0] arb_id
);
    arb_id_t    id_q;
    arb_id_t    id_d;
    round_evt_t ev;

    assign ev = '{valid: round_done, winner: arb_id_t'(winner_id), ok: tx_ok, lowpri: lowpri};

    arb_id_next u_next (
        .cur_id     (id_q),
        .reload     (id_wr || init_deassert),
        .reload_val (arb_id_t'(agent_id)),
        .round_ev   (ev),
        .next_id    (id_d)
    );

    always_ff @(posedge clk) begin
        if (rst) id_q <= '0;
        else     id_q <= id_d;
    end

    arb_race #(.W(ARB_ID_W)) u_race (
        .clk      (clk),
        .rst      (rst),
        .start    (arb_start),
        .id_in    (id_q),
        .line_in  (arb_line_in),
        .line_out (arb_line_out),
        .busy     (arb_busy),
        .won      (arb_won),
        .lost     (arb_lost)
    );

    assign arb_id = W'(id_q);
endmodule

// File: rtl/arb_id_tracker_chk.sv
module arb_id_tracker_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         id_wr,
    input logic         init_deassert,
    input logic [W-1:0] agent_id,
    input logic         round_done,
    input logic [W-1:0] winner_id,
    input logic         tx_ok,
    input logic         lowpri,
    input logic         arb_line_in,
    input logic         arb_line_out,
    input logic         arb_busy,
    input logic         arb_won,
    input logic         arb_lost,
    input logic [W-1:0] arb_id
);
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (arb_id == '0 && !arb_won && !arb_lost && !arb_busy));

    a_r2_id_write: assert property (@(posedge clk) disable iff (rst)
        id_wr |=> arb_id == $past(agent_id));

    a_r3_init_reload: assert property (@(posedge clk) disable iff (rst)
        init_deassert |=> arb_id == $past(agent_id));

    a_r4_self_to_zero: assert property (@(posedge clk) disable iff (rst)
        (round_done && (tx_ok || lowpri) && !id_wr && !init_deassert && arb_id == winner_id)
        |=> arb_id == '0);

    a_r7_failed_holds: assert property (@(posedge clk) disable iff (rst)
        (round_done && !tx_ok && !lowpri && !id_wr && !init_deassert) |=> $stable(arb_id));

    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        !arb_busy |-> arb_line_out);

    a_r11_dropout_stays: assert property (@(posedge clk) disable iff (rst)
        (arb_busy && arb_line_out && !arb_line_in) |=> arb_line_out);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(arb_won && arb_lost));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (arb_won || arb_lost) |=> !(arb_won || arb_lost));
endmodule

bind arb_id_tracker arb_id_tracker_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .id_wr         (id_wr),
    .init_deassert (init_deassert),
    .agent_id      (agent_id),
    .round_done    (round_done),
    .winner_id     (winner_id),
    .tx_ok         (tx_ok),
    .lowpri        (lowpri),
    .arb_line_in   (arb_line_in),
    .arb_line_out  (arb_line_out),
    .arb_busy      (arb_busy),
    .arb_won       (arb_won),
    .arb_lost      (arb_lost),
    .arb_id        (arb_id)
);

// File: tb/arb_id_tracker_bench.sv
`timescale 1ns/1ps
module arb_id_tracker_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_wr = 1'b0;
    logic       init_deassert = 1'b0;
    logic [3:0] agent_id = '0;
    logic       round_done = 1'b0;
    logic [3:0] winner_id = '0;
    logic       tx_ok = 1'b0;
    logic       lowpri = 1'b0;
    logic       arb_start = 1'b0;
    logic       rival_drv = 1'b1;
    logic       arb_line_in;
    logic       arb_line_out;
    logic       arb_busy;
    logic       arb_won;
    logic       arb_lost;
    logic [3:0] arb_id;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    assign arb_line_in = arb_line_out & rival_drv;

    arb_id_tracker u_arb_id_tracker (
        .clk(clk), .rst(rst), .id_wr(id_wr), .init_deassert(init_deassert),
        .agent_id(agent_id), .round_done(round_done), .winner_id(winner_id),
        .tx_ok(tx_ok), .lowpri(lowpri), .arb_start(arb_start),
        .arb_line_in(arb_line_in), .arb_line_out(arb_line_out),
        .arb_busy(arb_busy), .arb_won(arb_won), .arb_lost(arb_lost),
        .arb_id(arb_id)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_id(input logic [3:0] v);
        @(negedge clk);
        agent_id = v; id_wr = 1'b1;
        @(negedge clk);
        id_wr = 1'b0;
    endtask

    // rotation rule worked out arithmetically
    function automatic int rot_exp(input int cur, input int win, input bit ok, input bit lp);
        if (!(ok || lp)) return cur;
        if (cur == win) return 0;
        if (cur == 15) return (win + 1) % 16;
        return cur + 1;
    endfunction

    task automatic round_case(input int cur, input int win, input bit ok, input bit lp);
        string tag;
        load_id(4'(cur));
        round_done = 1'b1; winner_id = 4'(win); tx_ok = ok; lowpri = lp;
        @(negedge clk);
        round_done = 1'b0; tx_ok = 1'b0; lowpri = 1'b0;
        if (!(ok || lp))      tag = "R7";
        else if (cur == win)  tag = (ok) ? "R4" : "R8";
        else if (cur == 15)   tag = (ok) ? "R5" : "R8";
        else                  tag = (ok) ? "R6" : "R8";
        check(tag, arb_id, rot_exp(cur, win, ok, lp));
    endtask

    task automatic race_case(input int own, input int rival, input bit poke);
        bit own_in = 1, riv_in = 1;
        logic line;
        logic exp_out;
        load_id(4'(own));
        arb_start = 1'b1;
        @(negedge clk);
        arb_start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int b = 3 - k;
            rival_drv = riv_in ? ~rival[b] : 1'b1;
            if (poke) arb_start = (k == 1);
            #1;
            exp_out = own_in ? ~own[b] : 1'b1;
            check("R10", arb_line_out, exp_out);
            line = exp_out & rival_drv;
            if (exp_out && !line) own_in = 0;
            if (rival_drv && !line) riv_in = 0;
            if (!own_in) begin end
            @(negedge clk);
        end
        rival_drv = 1'b1;
        arb_start = 1'b0;
        check("R12", arb_won, (own > rival) ? 1 : 0);
        check("R11", arb_lost, (own > rival) ? 0 : 1);
        @(negedge clk);
        check("R12", arb_won | arb_lost, 0);
        if (poke) begin
            check("R13", arb_busy, 0);
            check("R13", arb_line_out, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", arb_id, 0);
        check("R1", arb_line_out, 1);
        check("R1", arb_busy | arb_won | arb_lost, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", arb_id, 0);

        // R2: every ID value via the register write
        for (int v = 0; v < 16; v++) begin
            load_id(4'(v));
            check("R2", arb_id, v);
        end

        // R3: INIT deassert reload after a rotation moved the value
        load_id(4'd5);
        round_done = 1'b1; winner_id = 4'd9; tx_ok = 1'b1;
        @(negedge clk);
        round_done = 1'b0; tx_ok = 1'b0;
        check("R6", arb_id, 6);
        agent_id = 4'd12; init_deassert = 1'b1;
        @(negedge clk);
        init_deassert = 1'b0;
        check("R3", arb_id, 12);

        // R9: reload and round in the same cycle
        agent_id = 4'd3; id_wr = 1'b1;
        round_done = 1'b1; winner_id = 4'd12; tx_ok = 1'b1;
        @(negedge clk);
        id_wr = 1'b0; round_done = 1'b0; tx_ok = 1'b0;
        check("R9", arb_id, 3);
        agent_id = 4'd7; init_deassert = 1'b1;
        round_done = 1'b1; winner_id = 4'd3; lowpri = 1'b1;
        @(negedge clk);
        init_deassert = 1'b0; round_done = 1'b0; lowpri = 1'b0;
        check("R9", arb_id, 7);

        // R4..R8: full sweep of rotation rule
        for (int c = 0; c < 16; c++)
            for (int w = 0; w < 16; w++)
                for (int f = 0; f < 4; f++)
                    round_case(c, w, f[0], f[1]);

        // R10..R12: every ordered pair of distinct IDs
        for (int a = 0; a < 16; a++)
            for (int r = 0; r < 16; r++)
                if (a != r) race_case(a, r, 1'b0);

        // R13: start request in the middle of a race
        race_case(9, 6, 1'b1);
        race_case(2, 14, 1'b1);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule